// File: doc/BRIEF.md
# Speculative Source-Field Hazard Detector

This block finds read-after-write hazards for the decode stage of a single-issue, in-order pipeline that has no forwarding and uses 16-bit instruction words. It does not decode the opcode to learn which registers an instruction reads. It takes every fixed bit-field that any instruction might use as a source register number and compares all of them at once with the destination registers of the instructions in the execute and memory stages. This removes the full decoder from the hazard path. The cost is an occasional stall that is not needed, when a field that is really an immediate or an opcode bit happens to equal an in-flight destination.

Two classes of instruction bypass the field comparison. Source-less instructions are recognised in fetch by a small mask/value pattern table. The flag is registered next to the word into decode, and such an instruction never stalls. Multi-register transfer instructions, whose sources are a register bit vector, are recognised in decode by a second pattern table. They stall whenever any in-flight instruction writes a register. The stall output holds the decode register and stops issue, so a bubble enters execute.

Top module: `spec_src_hazard`

## Requirements
- R1: While `rst` is high at a clock edge, the decode slot becomes empty after that edge (`dec_valid`=0) and `stall` is 0.
- R2: On a clock edge with `stall` low, the decode slot loads `fetch_valid` and `fetch_instr`. `issue_valid` is high exactly when the slot is occupied and `stall` is low.
- R3: While `stall` is high, the decode slot keeps its word and stays occupied, whatever fetch presents.
- R4: For an ordinary instruction in decode, `stall` is high when any of these candidates equals the destination of a qualifying in-flight stage: bits [8:5], bits [7:4], bits [3:0], or {bits [3:1], 0} or {bits [3:1], 1}. The last two treat bits [3:1] as naming an even/odd register pair. A candidate can match even when the instruction does not really read that field.
- R5: An in-flight stage qualifies only when both its valid and its write-enable inputs are high. Without a qualifying stage, `stall` is 0.
- R6: A word that matches a source-less pattern never stalls. With the defaults, these are words whose bits [15:12] are 4'hE or 4'hD.
- R7: A word that matches an encoded-vector pattern stalls whenever at least one in-flight stage qualifies, whatever its destination. With the default, these are words whose bits [15:9] are 7'b1001110. Source-less classification takes precedence.
- R8: With the decode slot empty, `stall` is 0.
- R9: `stall` is decided in the same cycle from the current in-flight inputs. It drops in the first cycle in which no candidate matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch presents a word |
| fetch_instr | input | 16 | Fetched instruction word |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_rd | input | 4 | Execute destination register |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_rd | input | 4 | Memory destination register |
| dec_valid | output | 1 | Decode slot occupied |
| dec_instr | output | 16 | Word held in decode |
| stall | output | 1 | Hold decode and inject a bubble |
| issue_valid | output | 1 | Decode word issues this cycle |

## Verification
The bench hits each candidate field separately, including both halves of the register pair. A design that dropped the odd or even half, or shifted a field by one bit, would miss a hazard and issue too early. It applies matching tags on stages that are invalid or non-writing, where a design that ignored the qualifiers would stall for nothing. It sends source-less words whose low bits match, and vector-class words whose destinations match no field. A wrong class decode would stall in the first case or let the second issue. It also changes the fetch word during a long stall and releases the stall within a cycle, which catches a decode register that does not hold and a stall that lingers one cycle too long.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_W   = 4;
  localparam int N_STAGE = 2;           // 0: execute, 1: memory
  localparam int N_CAND  = 5;
  localparam int PAIR_W  = REG_W - 1;
  // lowest bit positions of the candidate source fields
  localparam int F_HI_LSB   = 5;
  localparam int F_MID_LSB  = 4;
  localparam int F_LO_LSB   = 0;
  localparam int F_PAIR_LSB = 1;
  localparam int FIELD_W    = F_HI_LSB + REG_W;   // bits the fields span

  typedef struct packed {
    logic             valid;
    logic             wr;
    logic [REG_W-1:0] rd;
  } slot_t;
endpackage

// File: rtl/hzd_pattern_match.sv
module hzd_pattern_match #(
  parameter int W = 16,
  parameter int N = 1,
  parameter logic [N-1:0][W-1:0] MASK  = '0,
  parameter logic [N-1:0][W-1:0] VALUE = '0
) (
  input  logic [W-1:0] word,
  output logic         hit
);
  logic [N-1:0] each;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pat
      assign each[i] = ((word & MASK[i]) == VALUE[i]);
    end
  endgenerate

  assign hit = |each;
endmodule

// File: rtl/hzd_cand_extract.sv
module hzd_cand_extract
  import hzd_pkg::*;
(
  input  logic [FIELD_W-1:0]            field,
  output logic [N_CAND-1:0][REG_W-1:0]  cand
);
  always_comb begin
    cand[0] = field[F_HI_LSB  +: REG_W];
    cand[1] = field[F_MID_LSB +: REG_W];
    cand[2] = field[F_LO_LSB  +: REG_W];
    cand[3] = {field[F_PAIR_LSB +: PAIR_W], 1'b0};
    cand[4] = {field[F_PAIR_LSB +: PAIR_W], 1'b1};
  end
endmodule

// File: rtl/hzd_tag_compare.sv
module hzd_tag_compare
  import hzd_pkg::*;
#(
  parameter int NC = N_CAND,
  parameter int NS = N_STAGE
) (
  input  logic [NC-1:0][REG_W-1:0] cand,
  input  slot_t [NS-1:0]           slot,
  output logic                     any_match,
  output logic                     any_writer
);
  logic [NS-1:0]         writer;
  logic [NS-1:0][NC-1:0] hit;

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      assign writer[s] = slot[s].valid & slot[s].wr;
      for (genvar c = 0; c < NC; c++) begin : g_cand
        assign hit[s][c] = writer[s] & (cand[c] == slot[s].rd);
      end
    end
  endgenerate

  assign any_match  = |hit;
  assign any_writer = |writer;
endmodule

// File: rtl/spec_src_hazard.sv
module spec_src_hazard
  import hzd_pkg::*;
#(
  parameter int SL_N = 2,
  parameter logic [SL_N-1:0][INSTR_W-1:0] SL_MASK  = {16'hF000, 16'hF000},
  parameter logic [SL_N-1:0][INSTR_W-1:0] SL_VALUE = {16'hE000, 16'hD000},
  parameter int EV_N = 1,
  parameter logic [EV_N-1:0][INSTR_W-1:0] EV_MASK  = {16'hFE00},
  parameter logic [EV_N-1:0][INSTR_W-1:0] EV_VALUE = {16'h9C00}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic               ex_valid,
  input  logic               ex_wr,
  input  logic [REG_W-1:0]   ex_rd,
  input  logic               mem_valid,
  input  logic               mem_wr,
  input  logic [REG_W-1:0]   mem_rd,
  output logic               dec_valid,
  output logic [INSTR_W-1:0] dec_instr,
  output logic               stall,
  output logic               issue_valid
);
  logic                        fetch_sl;
  logic                        dec_sl;
  logic                        dec_ev;
  logic [N_CAND-1:0][REG_W-1:0] cand;
  slot_t [N_STAGE-1:0]         slot;
  logic                        any_match;
  logic                        any_writer;

  // fetch-side source-less classifier
  hzd_pattern_match #(
    .W(INSTR_W), .N(SL_N), .MASK(SL_MASK), .VALUE(SL_VALUE)
  ) u_sl_class (
    .word (fetch_instr),
    .hit  (fetch_sl)
  );

  // decode slot, held while stalled
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_instr <= '0;
      dec_sl    <= 1'b0;
    end else if (!stall) begin
      dec_valid <= fetch_valid;
      dec_instr <= fetch_instr;
      dec_sl    <= fetch_sl;
    end
  end

  // decode-side encoded-vector classifier
  hzd_pattern_match #(
    .W(INSTR_W), .N(EV_N), .MASK(EV_MASK), .VALUE(EV_VALUE)
  ) u_ev_class (
    .word (dec_instr),
    .hit  (dec_ev)
  );

  hzd_cand_extract u_extract (
    .field (dec_instr[FIELD_W-1:0]),
    .cand  (cand)
  );

  assign slot[0] = '{valid: ex_valid,  wr: ex_wr,  rd: ex_rd};
  assign slot[1] = '{valid: mem_valid, wr: mem_wr, rd: mem_rd};

  hzd_tag_compare #(.NC(N_CAND), .NS(N_STAGE)) u_compare (
    .cand       (cand),
    .slot       (slot),
    .any_match  (any_match),
    .any_writer (any_writer)
  );

  always_comb begin
    if (!dec_valid || dec_sl) stall = 1'b0;
    else if (dec_ev)          stall = any_writer;
    else                      stall = any_match;
  end

  assign issue_valid = dec_valid & ~stall;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker
  import hzd_pkg::*;
#(
  parameter int SL_N = 2,
  parameter logic [SL_N-1:0][INSTR_W-1:0] SL_MASK  = {16'hF000, 16'hF000},
  parameter logic [SL_N-1:0][INSTR_W-1:0] SL_VALUE = {16'hE000, 16'hD000},
  parameter int EV_N = 1,
  parameter logic [EV_N-1:0][INSTR_W-1:0] EV_MASK  = {16'hFE00},
  parameter logic [EV_N-1:0][INSTR_W-1:0] EV_VALUE = {16'h9C00}
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_valid,
  input logic [INSTR_W-1:0] fetch_instr,
  input logic               ex_valid,
  input logic               ex_wr,
  input logic               mem_valid,
  input logic               mem_wr,
  input logic               dec_valid,
  input logic [INSTR_W-1:0] dec_instr,
  input logic               stall
);
  logic any_wr;
  logic is_sl;
  logic is_ev;

  assign any_wr = (ex_valid && ex_wr) || (mem_valid && mem_wr);

  always_comb begin
    is_sl = 1'b0;
    for (int i = 0; i < SL_N; i++)
      if ((dec_instr & SL_MASK[i]) == SL_VALUE[i]) is_sl = 1'b1;
    is_ev = 1'b0;
    for (int i = 0; i < EV_N; i++)
      if ((dec_instr & EV_MASK[i]) == EV_VALUE[i]) is_ev = 1'b1;
  end

  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !dec_valid);

  a_r2_capture_valid: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (dec_valid == $past(fetch_valid)));

  a_r2_capture_word: assert property (@(posedge clk) disable iff (rst)
    (!stall && fetch_valid) |=> (dec_instr == $past(fetch_instr)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (dec_valid && $stable(dec_instr)));

  a_r5_no_writer: assert property (@(posedge clk) disable iff (rst)
    !any_wr |-> !stall);

  a_r6_srcless: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && is_sl) |-> !stall);

  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && is_ev && !is_sl && any_wr) |-> stall);

  a_r8_empty: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !stall);
endmodule

bind spec_src_hazard hzd_checker u_hzd_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .fetch_instr (fetch_instr),
  .ex_valid    (ex_valid),
  .ex_wr       (ex_wr),
  .mem_valid   (mem_valid),
  .mem_wr      (mem_wr),
  .dec_valid   (dec_valid),
  .dec_instr   (dec_instr),
  .stall       (stall)
);

// File: tb/tb_spec_src_hazard.sv
module tb_spec_src_hazard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_instr = '0;
  logic        ex_valid = 1'b0, ex_wr = 1'b0;
  logic [3:0]  ex_rd = '0;
  logic        mem_valid = 1'b0, mem_wr = 1'b0;
  logic [3:0]  mem_rd = '0;
  logic        dec_valid, stall, issue_valid;
  logic [15:0] dec_instr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spec_src_hazard dut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .ex_valid(ex_valid), .ex_wr(ex_wr), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .dec_valid(dec_valid), .dec_instr(dec_instr),
    .stall(stall), .issue_valid(issue_valid)
  );

  typedef struct packed {
    logic [15:0] instr;
    logic        exv, exw;
    logic [3:0]  exr;
    logic        mv, mw;
    logic [3:0]  mr;
    logic        exp_stall;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 4'd0,  1'b1, 4'd4}, // R4 [7:4]
    '{16'h1234, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd1,  1'b1, 4'd4}, // R4 [8:5]
    '{16'h1234, 1'b1, 1'b1, 4'd5,  1'b0, 1'b0, 4'd0,  1'b1, 4'd4}, // R4 odd pair, false hazard
    '{16'h1234, 1'b1, 1'b1, 4'd4,  1'b0, 1'b0, 4'd0,  1'b1, 4'd4}, // R4 [3:0]
    '{16'h1234, 1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 4'd6,  1'b0, 4'd4}, // R4 no field matches
    '{16'h1234, 1'b1, 1'b0, 4'd3,  1'b0, 1'b0, 4'd0,  1'b0, 4'd5}, // R5 not writing
    '{16'h1234, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 4'd1,  1'b0, 4'd5}, // R5 invalid / not writing
    '{16'hE234, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 4'd0,  1'b0, 4'd6}, // R6 source-less E
    '{16'hD031, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd3,  1'b0, 4'd6}, // R6 source-less D
    '{16'h9C00, 1'b1, 1'b1, 4'd15, 1'b0, 1'b0, 4'd0,  1'b1, 4'd7}, // R7 any writer
    '{16'h9D55, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd14, 1'b1, 4'd7}, // R7 memory writer
    '{16'h9C00, 1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b0, 4'd7}, // R7 no writer
    '{16'h0F0F, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd8,  1'b1, 4'd4}, // R4 [8:5]=8
    '{16'h0F0F, 1'b1, 1'b1, 4'd14, 1'b0, 1'b0, 4'd0,  1'b1, 4'd4}, // R4 even pair
    '{16'h0F0F, 1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 4'd7,  1'b0, 4'd4}, // R4 near misses
    '{16'h7FE0, 1'b1, 1'b1, 4'd1,  1'b0, 1'b0, 4'd0,  1'b1, 4'd4}  // R4 odd pair of zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inflight();
    ex_valid = 1'b0; ex_wr = 1'b0; ex_rd = '0;
    mem_valid = 1'b0; mem_wr = 1'b0; mem_rd = '0;
  endtask

  // put a word into decode with nothing in flight
  task automatic load(input logic [15:0] w);
    @(negedge clk);
    idle_inflight();
    fetch_valid = 1'b1;
    fetch_instr = w;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 stall", stall, 0);
    rst = 1'b0;

    // R8: empty slot never stalls even with matching writers
    @(negedge clk);
    ex_valid = 1'b1; ex_wr = 1'b1; ex_rd = 4'd0;
    #1 chk("R8 empty stall", stall, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      load(VECS[i].instr);
      chk("R2 captured word", dec_instr, VECS[i].instr);
      chk("R2 captured valid", dec_valid, 1);
      ex_valid = VECS[i].exv; ex_wr = VECS[i].exw; ex_rd = VECS[i].exr;
      mem_valid = VECS[i].mv; mem_wr = VECS[i].mw; mem_rd = VECS[i].mr;
      #1;
      n_chk++;
      if (stall !== VECS[i].exp_stall) begin
        n_fail++;
        $display("FAIL R%0d vector %0d stall: actual %0b expected %0b",
                 VECS[i].req, i, stall, VECS[i].exp_stall);
      end
      chk("R2 issue_valid", issue_valid, !VECS[i].exp_stall);
    end

    // R3: hold during a multi-cycle stall while fetch changes, R9 release
    load(16'h1234);
    ex_valid = 1'b1; ex_wr = 1'b1; ex_rd = 4'd3;
    fetch_valid = 1'b1; fetch_instr = 16'hABCD;
    for (int c = 0; c < 3; c++) begin
      #1 chk("R3 stall held", stall, 1);
      chk("R3 issue blocked", issue_valid, 0);
      @(negedge clk);
      chk("R3 word held", dec_instr, 16'h1234);
      chk("R3 valid held", dec_valid, 1);
    end
    ex_rd = 4'd9;
    #1 chk("R9 stall drops", stall, 0);
    chk("R9 issue", issue_valid, 1);
    @(negedge clk);
    chk("R2 next word", dec_instr, 16'hABCD);

    // R1: reset mid-run empties the slot
    fetch_valid = 1'b1; fetch_instr = 16'h0000;
    idle_inflight();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset dec_valid", dec_valid, 0);
    chk("R1 reset stall", stall, 0);
    rst = 1'b0;
    fetch_valid = 1'b0;

    @(negedge clk);
    finish_run();
  end
endmodule